// File: doc/BRIEF.md
# Memory Refresh Request Generator

The block keeps dynamic or pseudo-static memory alive by asking the bus unit for a memory read cycle at fixed intervals. A programmable down-counter, clocked by the system clock, marks each interval. When the counter expires, the block raises a request. It holds that request until the bus unit grants it. Completion of the read cycle is reported on a done strobe.

The refresh address combines two parts. The low part comes from a row counter that advances once per completed refresh. The high part is a block base that software programs, so the refreshed window can sit on any 8 KB aligned region of a 1 MB space. Software loads the enable bit, the interval and the base in one write strobe. The bus cycle itself and the memory interface belong to the bus unit.

Top module: `rfsh_gen`

## Requirements
- R1: After reset, `req_o` is 0, `addr_o` is all zeros and the block is disabled: no request appears until a write sets the enable bit.
- R2: A write that sets enable while the block is disabled loads the counter from `cfg_interval_i`. The first request becomes visible I+1 clock edges after the write edge, where I is the interval value. Later expiries occur every I+1 cycles.
- R3: A request that is not granted stays asserted across further expiries, and those expiries queue no extra request. After the refresh completes, `req_o` stays low until the next scheduled expiry.
- R4: `gnt_i` sampled with `req_o` high drops `req_o` on the next cycle. A `done_i` pulse that ends a granted cycle advances the row field by exactly one.
- R5: `addr_o` bit 0 is always 0, bits 12:1 carry the row counter and bits 19:13 carry the programmed base. The base changes only on a write strobe.
- R6: The row counter wraps from 4095 to 0.
- R7: A write that clears enable drops a pending request on the next cycle and stops the counter. `done_i` outside a granted cycle leaves the row unchanged.
- R8: An expiry that falls inside a granted cycle, before `done_i`, yields a request on the cycle right after `done_i`.
- R9: Writes that leave enable cleared update the base but never produce a request.

Top module ports and their meaning:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load strobe for enable, interval and base |
| cfg_en_i | input | 1 | Enable value to load |
| cfg_interval_i | input | 9 | Interval value to load (clocks between requests minus one) |
| cfg_base_i | input | 7 | Block base value to load (address bits 19:13) |
| gnt_i | input | 1 | Bus unit accepts the pending refresh request |
| done_i | input | 1 | Granted refresh read cycle has finished |
| req_o | output | 1 | Refresh read cycle requested |
| addr_o | output | 20 | Refresh address |

## Verification
A wrong interval counter shows up as a request edge that is early or late against I+1. The bench sweeps many intervals, so an off-by-one appears within the first period after enable. A broken request state shows up as a request that vanishes without a grant, reappears just after a refresh, or survives a disable, each within one or two cycles. A wrong row counter or address mapping appears on `addr_o` after the next `done_i`. The wrap is covered by running 4100 back-to-back refreshes, and the base mapping by sweeping all 128 values.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_BUSY = 2'd2
  } rf_state_e;
endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs #(
  parameter int unsigned IVL_W  = 9,
  parameter int unsigned BASE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [IVL_W-1:0]  ivl_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              en_o,
  output logic [IVL_W-1:0]  ivl_o,
  output logic [BASE_W-1:0] base_o,
  output logic              start_o,
  output logic              kill_o
);
  logic              en_q;
  logic [IVL_W-1:0]  ivl_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ivl_q  <= '0;
      base_q <= '0;
    end else if (wr_i) begin
      en_q   <= en_i;
      ivl_q  <= ivl_i;
      base_q <= base_i;
    end
  end

  assign en_o    = en_q;
  assign ivl_o   = ivl_q;
  assign base_o  = base_q;
  assign start_o = wr_i & en_i & ~en_q;  // off -> on: reload counter
  assign kill_o  = wr_i & ~en_i;
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned IVL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [IVL_W-1:0] load_val_i,
  input  logic [IVL_W-1:0] reload_val_i,
  output logic             expire_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_i & at_zero & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (run_i) begin
      if (at_zero)       cnt_q <= reload_val_i;
      else               cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_req_fsm.sv
module rfsh_req_fsm
  import rfsh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic kill_i,
  input  logic gnt_i,
  input  logic done_i,
  output logic req_o,
  output logic row_inc_o
);
  rf_state_e state_q, state_d;
  logic      pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      RF_IDLE: if (expire_i && !kill_i) state_d = RF_REQ;
      RF_REQ: begin
        if (kill_i)     state_d = RF_IDLE;
        else if (gnt_i) state_d = RF_BUSY;
      end
      RF_BUSY: begin
        if (done_i) begin
          state_d = ((pend_q || expire_i) && !kill_i) ? RF_REQ : RF_IDLE;
          pend_d  = 1'b0;
        end else if (expire_i) begin
          pend_d  = 1'b1;
        end
      end
      default: state_d = RF_IDLE;
    endcase
    if (kill_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign req_o     = (state_q == RF_REQ);
  assign row_inc_o = (state_q == RF_BUSY) & done_i;
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;  // natural wrap
  end

  assign row_o = row_q;
endmodule

// File: rtl/rfsh_gen.sv
module rfsh_gen #(
  parameter int unsigned IVL_W  = 9,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BASE_W = 7,
  localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_en_i,
  input  logic [IVL_W-1:0]  cfg_interval_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic              gnt_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              en_q, start, kill, expire, row_inc;
  logic [IVL_W-1:0]  ivl_q;
  logic [BASE_W-1:0] base_q;
  logic [ROW_W-1:0]  row_q;

  rfsh_cfg_regs #(.IVL_W(IVL_W), .BASE_W(BASE_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .en_i    (cfg_en_i),
    .ivl_i   (cfg_interval_i),
    .base_i  (cfg_base_i),
    .en_o    (en_q),
    .ivl_o   (ivl_q),
    .base_o  (base_q),
    .start_o (start),
    .kill_o  (kill)
  );

  rfsh_interval_timer #(.IVL_W(IVL_W)) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (en_q),
    .load_i       (start),
    .load_val_i   (cfg_interval_i),
    .reload_val_i (ivl_q),
    .expire_o     (expire)
  );

  rfsh_req_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .kill_i    (kill),
    .gnt_i     (gnt_i),
    .done_i    (done_i),
    .req_o     (req_o),
    .row_inc_o (row_inc)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (row_inc),
    .row_o  (row_q)
  );

  assign addr_o = {base_q, row_q, 1'b0};  // word-aligned refresh access
endmodule

// File: rtl/rfsh_gen_chk.sv
module rfsh_gen_chk #(
  parameter int unsigned IVL_W  = 9,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BASE_W = 7,
  localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic              cfg_en_i,
  input logic              gnt_i,
  input logic              done_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] addr_o
);
  AST_GNT_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> !req_o); // R4

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i && !(cfg_wr_i && !cfg_en_i) |=> req_o); // R3

  AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !cfg_en_i |=> !req_o); // R7

  AST_ROW_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o[ROW_W:1]) |-> addr_o[ROW_W:1] == $past(addr_o[ROW_W:1]) + 1'b1); // R6

  AST_ROW_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(addr_o[ROW_W:1])); // R7

  AST_BASE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(addr_o[ADDR_W-1:ROW_W+1])); // R5
endmodule

bind rfsh_gen rfsh_gen_chk #(.IVL_W(IVL_W), .ROW_W(ROW_W), .BASE_W(BASE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_wr_i (cfg_wr_i),
  .cfg_en_i (cfg_en_i),
  .gnt_i    (gnt_i),
  .done_i   (done_i),
  .req_o    (req_o),
  .addr_o   (addr_o)
);

// File: tb/tb_rfsh_gen.sv
module tb_rfsh_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_en_i = 1'b0;
  logic [8:0]  cfg_interval_i = '0;
  logic [6:0]  cfg_base_i = '0;
  logic        gnt_i = 1'b0;
  logic        done_i = 1'b0;
  logic        req_o;
  logic [19:0] addr_o;

  int checks = 0;
  int errors = 0;
  int exp_row = 0;
  int cycles = 0;
  logic [6:0] cur_base = '0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rfsh_gen dut (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg_write(input logic en, input int ivl, input logic [6:0] base);
    cfg_wr_i = 1'b1; cfg_en_i = en; cfg_interval_i = ivl[8:0]; cfg_base_i = base;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    cur_base = base;
  endtask

  function automatic logic [19:0] exp_addr();
    return {cur_base, exp_row[11:0], 1'b0};
  endfunction

  task automatic wait_req(output int n);
    n = 0;
    while (!req_o && n < 600) begin
      step();
      n++;
    end
  endtask

  task automatic refresh(input int hold);
    gnt_i = 1'b1;
    step();
    gnt_i = 1'b0;
    chk("R4 req drops after grant", req_o, 1'b0);
    for (int i = 0; i < hold; i++) step();
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    exp_row = (exp_row + 1) % 4096;
  endtask

  initial begin
    int n;
    @(negedge clk_i);
    chk("R1 req in reset", req_o, 1'b0);
    rst_ni = 1'b1;
    step();
    chk("R1 req after reset", req_o, 1'b0);
    chk("R1 addr after reset", addr_o, 20'h0);
    for (int i = 0; i < 600; i++) begin
      step();
      if (req_o) break;
    end
    chk("R1 no request while disabled", req_o, 1'b0);

    // R9 / R5: exhaustive base sweep with enable off
    for (int b = 0; b < 128; b++) begin
      cfg_write(1'b0, 3, b[6:0]);
      chk("R5 base field", addr_o, exp_addr());
      chk("R9 no request when disabled", req_o, 1'b0);
    end

    // R2: first request timing over a sweep of intervals
    for (int iv = 0; iv < 24; iv++) begin
      cfg_write(1'b1, iv, 7'h12);
      wait_req(n);
      chk("R2 first request delay", n, iv + 1);
      cfg_write(1'b0, iv, 7'h12);
      chk("R7 disable drops request", req_o, 1'b0);
    end
    cfg_write(1'b1, 511, 7'h12);
    wait_req(n);
    chk("R2 max interval delay", n, 512);

    // R7: disable stops everything, stray done ignored
    cfg_write(1'b0, 511, 7'h12);
    chk("R7 request dropped", req_o, 1'b0);
    done_i = 1'b1; step(); done_i = 1'b0;
    for (int i = 0; i < 40; i++) step();
    chk("R7 stays idle", req_o, 1'b0);
    chk("R7 row unchanged by stray done", addr_o, exp_addr());

    // R3: pending request held, no extra queued
    cfg_write(1'b1, 20, 7'h12);
    wait_req(n);
    chk("R2 interval 20 delay", n, 21);
    begin
      logic held = 1'b1;
      for (int i = 0; i < 50; i++) begin
        step();
        held &= req_o;
      end
      chk("R3 request held across expiries", held, 1'b1);
    end
    refresh(0);
    chk("R3 no queued request after done", req_o, 1'b0);
    chk("R4 row advanced", addr_o, exp_addr());
    begin
      logic any = 1'b0;
      for (int i = 0; i < 10; i++) begin
        step();
        any |= req_o;
      end
      chk("R3 low until next expiry", any, 1'b0);
    end
    step();
    chk("R2 next expiry on schedule", req_o, 1'b1);

    // R8: expiry inside a granted cycle
    cfg_write(1'b0, 2, 7'h12);
    cfg_write(1'b1, 2, 7'h12);
    wait_req(n);
    chk("R2 interval 2 delay", n, 3);
    refresh(6);
    chk("R8 request right after done", req_o, 1'b1);
    chk("R4 row after R8 refresh", addr_o, exp_addr());

    // R6: back-to-back refreshes through the wrap
    cfg_write(1'b0, 0, 7'h55);
    cfg_write(1'b1, 0, 7'h55);
    begin
      int bad = 0;
      logic wrapped = 1'b0;
      for (int k = 0; k < 4100; k++) begin
        wait_req(n);
        refresh(0);
        if (addr_o !== exp_addr()) bad++;
        if (exp_row == 0) wrapped = 1'b1;
      end
      chk("R6 addresses through wrap", bad, 0);
      chk("R6 wrap reached", wrapped, 1'b1);
      chk("R5 final address layout", addr_o, exp_addr());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule